// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is one DMA channel that works through a circular ring of 8-byte descriptors held in memory. Each descriptor is two 32-bit words: a control word and a buffer address. The channel reads the control word through a synchronous memory port. If the descriptor belongs to hardware, it reads the buffer address and hands the buffer to a data-side stub through a request/acknowledge handshake. It then writes the control word back, which returns ownership to software and marks the descriptor done.

Software sets the ring base, the number of descriptors (64 by default), the direction, the enable and a polling switch. A soft reset request returns the channel to descriptor 0. When the channel meets a descriptor that software still owns, it waits. It then re-reads that descriptor at a fixed divided rate, or re-reads it once when it receives a kick pulse. Each finished descriptor raises a one-cycle event on bit 3 of the event vector.

Top module: `ring_dma_chan`

## Requirements
- R1: After `rst_n` is released, `mem_req`, `dat_req` and `rst_busy` are low, `evt` is 0 and `cur_idx` is 0. No memory access occurs while `chan_en` is low.
- R2: A fetch reads the control word at `ring_base + 8*cur_idx`. If the descriptor is owned, the next cycle reads the buffer address at that address + 4. Read data is valid on `mem_rdata` in the cycle after the request.
- R3: If control bit 31 (ownership) is 0, the descriptor is left alone: no data request and no write-back occur, and `evt[0]` pulses for one cycle.
- R4: For an owned descriptor, `dat_req` presents the following values until `dat_ack`: the buffer address, the length from control bits 15:0, the start flag from bit 29 and the end flag from bit 28. In transmit mode (`dir_tx`=1), the offset comes from bits 27:23.
- R5: In receive mode (`dir_tx`=0), `dat_off` carries only control bits 25:23. Its two upper bits are 0, whatever bits 27:26 hold.
- R6: The write-back is one write to the control word's address, with bit 31 cleared and bit 30 set. In transmit mode every other bit is unchanged.
- R7: In receive mode, the write-back replaces bits 15:0 with `dat_cnt` and bit 28 with `dat_last`, both captured at `dat_ack`. All other bits are kept as read.
- R8: `evt[3]` pulses for exactly one cycle, in the cycle of the write-back. `evt[2]` pulses with it when the written bit 28 is 1.
- R9: After a write-back, `cur_idx` advances by one. After index `ring_len-1` it wraps to 0, and `evt[1]` pulses with that write-back.
- R10: With `poll_en` high, an unowned descriptor is read again exactly `POLL_DIV` (4) cycles after its previous read. With `poll_en` low, it is read again only after a `kick` pulse, once per pulse.
- R11: A `soft_rst` pulse aborts any activity and sets `cur_idx` to 0. `rst_busy` is then high for `RST_CYC` (4) cycles and clears by itself, with no memory or data request during that time.
- R12: Dropping `chan_en` lets a descriptor already in transfer finish its write-back. After that, no further fetch is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| ring_len | input | IDXW+1 | Number of descriptors in the ring |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| chan_en | input | 1 | Channel enable |
| poll_en | input | 1 | Periodic re-read of an unowned descriptor |
| kick | input | 1 | One-shot re-read request |
| soft_rst | input | 1 | Channel reset request |
| rst_busy | output | 1 | Channel reset in progress |
| cur_idx | output | IDXW | Current descriptor index |
| evt | output | 4 | Pulses: [0] not owned, [1] wrap, [2] end flag written, [3] descriptor done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| dat_req | output | 1 | Buffer transfer request |
| dat_addr | output | AW | Buffer address |
| dat_len | output | 16 | Buffer length in bytes |
| dat_off | output | 5 | Byte offset |
| dat_sop | output | 1 | Start-of-packet flag |
| dat_eop | output | 1 | End-of-packet flag |
| dat_ack | input | 1 | Transfer finished |
| dat_cnt | input | 16 | Receive: bytes stored |
| dat_last | input | 1 | Receive: buffer holds the final packet byte |

## Verification
A wrong descriptor index shows up at once on `mem_addr` at the next fetch. It also shows as a wrap event in the wrong place in the ring. A stale or mis-captured control word shows up within one transfer: either as wrong fields on the data request, or as a write-back word whose length, flags or ownership bits differ from the value computed from the descriptor. A broken polling counter changes the gap between consecutive reads of an idle descriptor, which the bench measures in cycles. A channel stuck in reset, or stuck in any other state, stops the completion events, and the scoreboard's pending items are then left unmatched.

// File: rtl/ring_dma_chan.sv
module ring_dma_chan #(
  parameter int AW       = 32,
  parameter int IDXW     = 6,
  parameter int POLL_DIV = 4,
  parameter int RST_CYC  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ring_base,
  input  logic [IDXW:0]   ring_len,
  input  logic            dir_tx,
  input  logic            chan_en,
  input  logic            poll_en,
  input  logic            kick,
  input  logic            soft_rst,
  output logic            rst_busy,
  output logic [IDXW-1:0] cur_idx,
  output logic [3:0]      evt,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic            dat_req,
  output logic [AW-1:0]   dat_addr,
  output logic [15:0]     dat_len,
  output logic [4:0]      dat_off,
  output logic            dat_sop,
  output logic            dat_eop,
  input  logic            dat_ack,
  input  logic [15:0]     dat_cnt,
  input  logic            dat_last
);
  // POLL_DIV must be at least 3
  localparam int PW  = (POLL_DIV > 3) ? $clog2(POLL_DIV) : 1;
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam logic [PW-1:0]  PLIM = PW'(POLL_DIV - 3);

  typedef enum logic [2:0] {
    S_IDLE, S_FC, S_FA, S_LA, S_XF, S_WB, S_POLL, S_RST
  } st_t;

  st_t             st;
  logic [IDXW-1:0] idx;
  logic [31:0]     ctrl_q;
  logic [AW-1:0]   buf_q;
  logic [15:0]     rx_cnt_q;
  logic            rx_last_q;
  logic [PW-1:0]   pcnt;
  logic [RCW-1:0]  rcnt;

  logic [AW-1:0]   desc_addr;
  logic [IDXW:0]   len_m1;
  logic            at_last;
  logic            own_now;
  logic [31:0]     wb_word;

  assign desc_addr = ring_base + AW'({idx, 3'b000});
  assign len_m1    = ring_len - 1'b1;
  assign at_last   = ({1'b0, idx} == len_m1);
  assign own_now   = mem_rdata[31];

  assign wb_word = {1'b0, 1'b1, ctrl_q[29],
                    dir_tx ? ctrl_q[28] : rx_last_q,
                    ctrl_q[27:16],
                    dir_tx ? ctrl_q[15:0] : rx_cnt_q};

  assign mem_req   = (st == S_FC) || (st == S_FA && own_now) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = desc_addr + ((st == S_FA) ? AW'(4) : AW'(0));
  assign mem_wdata = wb_word;

  assign dat_req  = (st == S_XF);
  assign dat_addr = buf_q;
  assign dat_len  = ctrl_q[15:0];
  assign dat_off  = dir_tx ? ctrl_q[27:23] : {2'b00, ctrl_q[25:23]};
  assign dat_sop  = ctrl_q[29];
  assign dat_eop  = ctrl_q[28];

  assign evt[0] = (st == S_FA) && !own_now;
  assign evt[1] = (st == S_WB) && at_last;
  assign evt[2] = (st == S_WB) && wb_word[28];
  assign evt[3] = (st == S_WB);

  assign rst_busy = (st == S_RST);
  assign cur_idx  = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      ctrl_q    <= '0;
      buf_q     <= '0;
      rx_cnt_q  <= '0;
      rx_last_q <= 1'b0;
      pcnt      <= '0;
      rcnt      <= '0;
    end else if (soft_rst) begin
      st   <= S_RST;
      idx  <= '0;
      rcnt <= RCW'(RST_CYC - 1);
    end else begin
      case (st)
        S_RST: begin
          if (rcnt == '0) st <= S_IDLE;
          else            rcnt <= rcnt - 1'b1;
        end
        S_IDLE: if (chan_en && ring_len != '0) st <= S_FC;
        S_FC:   st <= S_FA;
        S_FA: begin
          ctrl_q <= mem_rdata;
          if (own_now) st <= S_LA;
          else begin
            pcnt <= '0;
            st   <= S_POLL;
          end
        end
        S_LA: begin
          buf_q <= mem_rdata;
          st    <= S_XF;
        end
        S_XF: if (dat_ack) begin
          rx_cnt_q  <= dat_cnt;
          rx_last_q <= dat_last;
          st        <= S_WB;
        end
        S_WB: begin
          idx <= at_last ? '0 : idx + 1'b1;
          st  <= chan_en ? S_FC : S_IDLE;
        end
        S_POLL: begin
          if (!chan_en)                              st <= S_IDLE;
          else if (kick || (poll_en && pcnt == PLIM)) st <= S_FC;
          else if (pcnt != PLIM)                     pcnt <= pcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_dma_chan_chk.sv
module ring_dma_chan_chk #(
  parameter int IDXW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic [31:0]     mem_wdata,
  input logic [3:0]      evt,
  input logic            rst_busy,
  input logic            dat_req,
  input logic [4:0]      dat_off,
  input logic            dir_tx,
  input logic [IDXW-1:0] cur_idx
);
  // R6
  wb_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (!mem_wdata[31] && mem_wdata[30]));
  // R8
  done_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[3] |-> (mem_req && mem_we));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[3] |=> !evt[3]);
  // R11
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> (!mem_req && !dat_req));
  // R9
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[1] |=> (cur_idx == '0));
  // R5
  rx_off_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_req && !dir_tx) |-> (dat_off[4:3] == 2'b00));
  // R3
  miss_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> !dat_req);
endmodule

bind ring_dma_chan ring_dma_chan_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .evt(evt), .rst_busy(rst_busy), .dat_req(dat_req),
  .dat_off(dat_off), .dir_tx(dir_tx), .cur_idx(cur_idx)
);

// File: tb/ring_dma_chan_tb.sv
module ring_dma_chan_tb;
  localparam int AW = 32, IDXW = 6;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] ring_base = BASE;
  logic [IDXW:0] ring_len = 3;
  logic dir_tx = 1, chan_en = 0, poll_en = 1, kick = 0, soft_rst = 0;
  logic rst_busy;
  logic [IDXW-1:0] cur_idx;
  logic [3:0] evt;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic dat_req, dat_sop, dat_eop;
  logic [AW-1:0] dat_addr;
  logic [15:0] dat_len;
  logic [4:0] dat_off;
  logic dat_ack = 0, dat_last = 0;
  logic [15:0] dat_cnt = 0;

  ring_dma_chan u_dut (.*);

  always #2 clk = ~clk;

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
  end

  int errors = 0, checks = 0;
  int cyc = 0;
  int done_cnt = 0, eop_cnt = 0, wrap_cnt = 0, miss_cnt = 0;
  int rd_cnt = 0, ctrl_rd_cnt = 0, prev_rd = 0, last_rd = 0;
  int dly = 0;
  bit prev_dreq = 0, finished = 0;
  logic [63:0] exp_wr_q[$];
  logic [54:0] exp_dat_q[$];
  logic [16:0] rx_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int i, input logic [31:0] ctrl, input logic [31:0] bufa,
                          input logic [15:0] rcnt, input logic rlast);
    logic [31:0] a, wb;
    logic [4:0] off;
    a = BASE + 32'(8 * i);
    mem[a[9:2]] = ctrl;
    mem[a[9:2] + 8'd1] = bufa;
    if (ctrl[31]) begin
      off = dir_tx ? ctrl[27:23] : {2'b00, ctrl[25:23]};
      exp_dat_q.push_back({bufa, ctrl[15:0], off, ctrl[29], ctrl[28]});
      wb = dir_tx ? {2'b01, ctrl[29:0]} : {2'b01, ctrl[29], rlast, ctrl[27:16], rcnt};
      exp_wr_q.push_back({a, wb});
      rx_q.push_back({rlast, rcnt});
    end
  endtask

  // monitor and data stub
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we) begin
        if (exp_wr_q.size() == 0) check(0, "R3 unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          logic [63:0] e;
          e = exp_wr_q.pop_front();
          check({mem_addr, mem_wdata} == e, dir_tx ? "R6 write-back" : "R7 write-back",
                {mem_addr, mem_wdata}, e);
        end
        check(evt[3], "R8 done with write", 64'(evt), 64'h8);
      end
      if (mem_req && !mem_we) begin
        rd_cnt++;
        check((mem_addr - BASE) < 32'(8 * ring_len), "R2 read address in ring", mem_addr, BASE);
        if (!mem_addr[2]) begin
          ctrl_rd_cnt++;
          prev_rd = last_rd;
          last_rd = cyc;
        end
      end
      if (dat_req && !prev_dreq) begin
        logic [54:0] got;
        got = {dat_addr, dat_len, dat_off, dat_sop, dat_eop};
        if (exp_dat_q.size() == 0) check(0, "R3 unexpected data request", 64'(got), 0);
        else begin
          logic [54:0] e;
          e = exp_dat_q.pop_front();
          check(got == e, dir_tx ? "R4 data request" : "R5 data request", 64'(got), 64'(e));
        end
      end
      prev_dreq = dat_req;
      if (evt[3]) done_cnt++;
      if (evt[2]) eop_cnt++;
      if (evt[1]) wrap_cnt++;
      if (evt[0]) miss_cnt++;
      if (dat_ack) dat_ack = 0;
      else if (dat_req) begin
        if (dly == 1) begin
          logic [16:0] r;
          r = (rx_q.size() != 0) ? rx_q.pop_front() : 17'h0;
          dat_last = r[16];
          dat_cnt = r[15:0];
          dat_ack = 1;
          dly = 0;
        end else dly++;
      end
    end
  end

  task automatic wait_done(input int n);
    for (int k = 0; k < 3000 && done_cnt < n; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int snap, n;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!mem_req && !dat_req && !rst_busy, "R1 idle outputs", {mem_req, dat_req, rst_busy}, 0);
    check(evt == 0, "R1 evt", 64'(evt), 0);
    check(cur_idx == 0, "R1 index", 64'(cur_idx), 0);
    repeat (20) @(negedge clk);
    check(rd_cnt == 0, "R1 no access while disabled", rd_cnt, 0);

    // transmit ring of three
    put_desc(0, 32'hA000_0040 | (32'h13 << 23), 32'h0001_0000, 0, 0);
    put_desc(1, 32'h8000_05DC, 32'h0002_0010, 0, 0);
    put_desc(2, 32'h9000_FFFF | (32'h1F << 23), 32'h0003_0020, 0, 0);
    chan_en = 1;
    wait_done(3);
    check(done_cnt == 3, "R8 done count", done_cnt, 3);
    check(eop_cnt == 1, "R8 eop count", eop_cnt, 1);
    check(wrap_cnt == 1, "R9 wrap count", wrap_cnt, 1);
    check(cur_idx == 0, "R9 wrapped index", 64'(cur_idx), 0);
    check(exp_wr_q.size() == 0 && exp_dat_q.size() == 0, "R6 all matched",
          exp_wr_q.size() + exp_dat_q.size(), 0);

    // polling of an unowned descriptor
    repeat (20) @(negedge clk);
    check(miss_cnt > 1, "R3 not-owned event", miss_cnt, 2);
    check(last_rd - prev_rd == 4, "R10 poll interval", last_rd - prev_rd, 4);
    check(done_cnt == 3, "R3 no write-back for unowned", done_cnt, 3);

    poll_en = 0;
    repeat (8) @(negedge clk);
    snap = ctrl_rd_cnt;
    repeat (40) @(negedge clk);
    check(ctrl_rd_cnt == snap, "R10 parked without poll", ctrl_rd_cnt, snap);
    kick = 1;
    @(negedge clk);
    kick = 0;
    repeat (5) @(negedge clk);
    check(ctrl_rd_cnt == snap + 1, "R10 kick one read", ctrl_rd_cnt, snap + 1);

    // disable during transfer
    put_desc(0, 32'hB000_0100, 32'h0004_0000, 0, 0);
    kick = 1;
    @(negedge clk);
    kick = 0;
    for (int k = 0; k < 50 && !dat_req; k++) @(negedge clk);
    chan_en = 0;
    wait_done(4);
    check(done_cnt == 4, "R12 in-flight descriptor finished", done_cnt, 4);
    check(cur_idx == 1, "R9 index advanced", 64'(cur_idx), 1);
    snap = rd_cnt;
    repeat (20) @(negedge clk);
    check(rd_cnt == snap, "R12 no fetch after disable", rd_cnt, snap);

    // soft reset
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    n = 0;
    while (rst_busy && n < 50) begin
      n++;
      @(negedge clk);
    end
    check(n == 4, "R11 busy cycles", n, 4);
    check(cur_idx == 0, "R11 index cleared", 64'(cur_idx), 0);

    // receive ring of two
    dir_tx = 0;
    ring_len = 2;
    poll_en = 1;
    put_desc(0, 32'hA000_0800 | (32'h1D << 23), 32'h0005_0000, 16'd700, 1'b0);
    put_desc(1, 32'h8000_0800 | (32'h02 << 23), 32'h0006_0000, 16'd33, 1'b1);
    chan_en = 1;
    wait_done(6);
    check(done_cnt == 6, "R7 receive done count", done_cnt, 6);
    check(eop_cnt == 3, "R7 eop from stub", eop_cnt, 3);
    check(wrap_cnt == 2, "R9 receive wrap", wrap_cnt, 2);
    check(exp_wr_q.size() == 0 && exp_dat_q.size() == 0, "R7 all matched",
          exp_wr_q.size() + exp_dat_q.size(), 0);
    chan_en = 0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule